// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block keeps the attribute settings that decide where accesses to the legacy memory area below one megabyte are sent. It covers the boot firmware region, the expansion-ROM strip below that region and the system-management RAM window. Software programs the settings through a byte-wide configuration port. For each memory access presented on the decode port, the block answers whether the access is claimed by DRAM or forwarded to the PCI bus.

The firmware region and the expansion strip are split into thirteen regions. Each region has a read-enable and a write-enable flag, so a region can be shadowed for reads only, for writes only, or for both. Regions are packed two per configuration byte. The first byte holds only one region's flags.

The graphics window at 0xA0000 is steered by an SMRAM control byte. An "open" flag hands the window to DRAM for every access. A global "SMRAM enable" flag hands it to DRAM for system-management-mode accesses only.

Top module: `smad_decoder`

## Requirements
- R1: After reset every attribute byte reads 0x00 and the SMRAM byte reads 0x02, so every firmware, expansion and SMRAM-window access goes to PCI whether it is SMM or not.
- R2: Configuration reads at offsets 0x59 to 0x5F and 0x72 return the stored byte; reads at any other offset return 0x00; writes to any other offset change no read value and no decode.
- R3: Bits 2:0 of the SMRAM byte at 0x72 always read 3'b010 whatever is written; bits 7:3 store the written value.
- R4: Region 0 spans 0xF0000 to 0xFFFFF. Region i (1 to 12) spans 0xC0000 + (i-1)*0x4000 for 0x4000 bytes. The SMRAM window spans 0xA0000 to 0xBFFFF, and no address falls in two of these windows.
- R5: Region i takes its flags from byte 0x59 + (i+1)/2 (integer division). Odd regions use bits 3:0 of that byte, and region 0 and the even regions use bits 7:4.
- R6: Within a region's nibble, bit 0 is read-enable and bit 1 is write-enable. A read goes to DRAM when read-enable is set and to PCI otherwise, and a write is steered the same way by write-enable.
- R7: A non-SMM access in the SMRAM window goes to DRAM when bit 6 (open) of byte 0x72 is set and to PCI when it is clear.
- R8: An SMM access in the SMRAM window goes to DRAM when bit 3 (SMRAM enable) of byte 0x72 is set, regardless of bit 6. Otherwise it follows R7.
- R9: An access outside every window reports no hit and goes to PCI.
- R10: The decode is combinational in the access address, direction and SMM flag. A configuration write is reflected by the decode and by read-back from the cycle after its clock edge.
- R11: Bits 3:0 of byte 0x59 are stored and read back but steer no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Configuration byte offset for read and write |
| cfg_wr | input | 1 | Write strobe for the byte at cfg_addr |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Byte stored at cfg_addr (0 when unmapped), combinational |
| acc_addr | input | ADDR_W (32) | Memory access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_smm | input | 1 | Access issued in system-management mode |
| tgt_dram | output | 1 | 1 when DRAM claims the access, 0 when forwarded to PCI |
| tgt_hit | output | 1 | Address lies inside one of the decoded windows |

## Verification
A wrong stored flag, or a flag taken from the wrong nibble or byte, shows at tgt_dram on the first access to the affected region in the matching direction. It shows no earlier, because the decode holds no state of its own. The reference model checks the read-back byte and the routing on every cycle, and the address sweep touches both edges of every region in both directions. A misplaced region edge or a swapped read/write flag is therefore reported within the sweep that follows each configuration pattern. A write that lands one cycle late, or on the wrong offset, is reported on the very next cycle through cfg_rdata.

// File: rtl/smad_pkg.sv
package smad_pkg;
   localparam int RE_BIT = 0;
   localparam int WE_BIT = 1;
   localparam int SMR_OPEN_BIT = 6;
   localparam int SMR_GEN_BIT = 3;
   localparam logic [2:0] SMR_FIXED = 3'b010;

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic bit aligned_pow2(input longint unsigned base, input longint unsigned size);
      return is_pow2(size) && ((base % size) == 0);
   endfunction
endpackage

// File: rtl/smad_cfg_regs.sv
module smad_cfg_regs
   import smad_pkg::*;
#(
   parameter int NUM_REGIONS = 13,
   parameter int ATTR_OFS    = 'h59,
   parameter int SMR_OFS     = 'h72
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [7:0]             cfg_addr,
   input  logic                   cfg_wr,
   input  logic [7:0]             cfg_wdata,
   output logic [7:0]             cfg_rdata,
   output logic [NUM_REGIONS-1:0] region_re,
   output logic [NUM_REGIONS-1:0] region_we,
   output logic                   smr_open,
   output logic                   smr_gen
);
   localparam int NUM_BYTES = NUM_REGIONS / 2 + 1;
   localparam logic [7:0] ATTR_OFS_B = 8'(ATTR_OFS);
   localparam logic [7:0] SMR_OFS_B  = 8'(SMR_OFS);

   logic [NUM_BYTES-1:0][7:0] attr_q;
   logic [7:3]                smr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr_q <= '0;
         smr_q  <= '0;
      end else if (cfg_wr) begin
         for (int b = 0; b < NUM_BYTES; b++) begin
            if (cfg_addr == ATTR_OFS_B + 8'(b)) attr_q[b] <= cfg_wdata;
         end
         if (cfg_addr == SMR_OFS_B) smr_q <= cfg_wdata[7:3];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (cfg_addr == ATTR_OFS_B + 8'(b)) cfg_rdata = attr_q[b];
      end
      if (cfg_addr == SMR_OFS_B) cfg_rdata = {smr_q, SMR_FIXED};
   end

   assign smr_open = smr_q[SMR_OPEN_BIT];
   assign smr_gen  = smr_q[SMR_GEN_BIT];

   for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
      localparam int BI = (r + 1) / 2;
      if (r % 2 == 1) begin : g_lo
         assign region_re[r] = attr_q[BI][RE_BIT];
         assign region_we[r] = attr_q[BI][WE_BIT];
      end else begin : g_hi
         assign region_re[r] = attr_q[BI][4 + RE_BIT];
         assign region_we[r] = attr_q[BI][4 + WE_BIT];
      end
   end

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_chk
      AST_ATTR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr && cfg_addr == ATTR_OFS_B + 8'(b)) |=> (attr_q[b] == $past(cfg_wdata))); // R2
   end

   AST_SMR_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr == SMR_OFS_B) |-> (cfg_rdata[2:0] == SMR_FIXED)); // R3

   AST_SMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_addr == SMR_OFS_B) |=> $stable(smr_q)); // R2
endmodule

// File: rtl/smad_region_match.sv
module smad_region_match
   import smad_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              NUM_EXP   = 12,
   parameter longint unsigned BIOS_BASE = 64'hF0000,
   parameter longint unsigned BIOS_SIZE = 64'h10000,
   parameter longint unsigned EXP_BASE  = 64'hC0000,
   parameter longint unsigned EXP_SIZE  = 64'h4000,
   parameter longint unsigned SMR_BASE  = 64'hA0000,
   parameter longint unsigned SMR_SIZE  = 64'h20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [NUM_EXP:0]  region_hit,
   output logic              smr_hit
);
   localparam int NUM_REGIONS = NUM_EXP + 1;
   localparam bit USE_MASK = aligned_pow2(BIOS_BASE, BIOS_SIZE) &&
                             aligned_pow2(EXP_BASE, EXP_SIZE) &&
                             aligned_pow2(SMR_BASE, SMR_SIZE);

   logic [NUM_REGIONS:0] hit_all;

   for (genvar r = 0; r <= NUM_REGIONS; r++) begin : g_win
      localparam longint unsigned LO =
         (r == 0)           ? BIOS_BASE :
         (r == NUM_REGIONS) ? SMR_BASE  :
                              EXP_BASE + 64'(r - 1) * EXP_SIZE;
      localparam longint unsigned SZ =
         (r == 0) ? BIOS_SIZE : (r == NUM_REGIONS) ? SMR_SIZE : EXP_SIZE;
      if (USE_MASK) begin : g_mask
         assign hit_all[r] = (acc_addr & ADDR_W'(~(SZ - 1))) == ADDR_W'(LO);
      end else begin : g_range
         assign hit_all[r] = ({1'b0, acc_addr} >= (ADDR_W+1)'(LO)) &&
                             ({1'b0, acc_addr} <  (ADDR_W+1)'(LO + SZ));
      end
   end

   assign region_hit = hit_all[NUM_REGIONS-1:0];
   assign smr_hit    = hit_all[NUM_REGIONS];

   AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({region_hit, smr_hit})); // R4
endmodule

// File: rtl/smad_route.sv
module smad_route #(
   parameter int NUM_REGIONS = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_REGIONS-1:0] region_hit,
   input  logic [NUM_REGIONS-1:0] region_re,
   input  logic [NUM_REGIONS-1:0] region_we,
   input  logic                   smr_hit,
   input  logic                   smr_open,
   input  logic                   smr_gen,
   input  logic                   acc_write,
   input  logic                   acc_smm,
   output logic                   tgt_dram,
   output logic                   tgt_hit
);
   logic shadow_dram;
   logic smr_dram;

   always_comb begin
      shadow_dram = 1'b0;
      for (int r = 0; r < NUM_REGIONS; r++) begin
         if (region_hit[r]) shadow_dram = acc_write ? region_we[r] : region_re[r];
      end
   end

   assign smr_dram = (acc_smm && smr_gen) || smr_open;
   assign tgt_hit  = smr_hit || (|region_hit);
   assign tgt_dram = smr_hit ? smr_dram : shadow_dram;

   AST_OUTSIDE_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_hit |-> !tgt_dram); // R9
   AST_SMM_ENABLED_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
      (smr_hit && acc_smm && smr_gen) |-> tgt_dram); // R8
   AST_NONSMM_FOLLOWS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (smr_hit && !acc_smm) |-> (tgt_dram == smr_open)); // R7
endmodule

// File: rtl/smad_decoder.sv
module smad_decoder #(
   parameter int              ADDR_W    = 32,
   parameter int              NUM_EXP   = 12,
   parameter longint unsigned BIOS_BASE = 64'hF0000,
   parameter longint unsigned BIOS_SIZE = 64'h10000,
   parameter longint unsigned EXP_BASE  = 64'hC0000,
   parameter longint unsigned EXP_SIZE  = 64'h4000,
   parameter longint unsigned SMR_BASE  = 64'hA0000,
   parameter longint unsigned SMR_SIZE  = 64'h20000,
   parameter int              ATTR_OFS  = 'h59,
   parameter int              SMR_OFS   = 'h72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cfg_addr,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_smm,
   output logic              tgt_dram,
   output logic              tgt_hit
);
   localparam int NUM_REGIONS = NUM_EXP + 1;
   localparam int NUM_BYTES   = NUM_REGIONS / 2 + 1;

   if (NUM_EXP < 1) begin : g_bad_exp
      $error("NUM_EXP must be at least 1");
   end
   if (ADDR_W < 21 || ADDR_W > 62) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (EXP_BASE + 64'(NUM_EXP) * EXP_SIZE > BIOS_BASE || SMR_BASE + SMR_SIZE > EXP_BASE) begin : g_bad_map
      $error("decoded windows overlap");
   end
   if (SMR_OFS >= ATTR_OFS && SMR_OFS < ATTR_OFS + NUM_BYTES) begin : g_bad_ofs
      $error("SMRAM offset overlaps attribute bytes");
   end
   if (ATTR_OFS + NUM_BYTES > 256 || SMR_OFS > 255) begin : g_bad_space
      $error("configuration offsets exceed byte space");
   end

   logic [NUM_REGIONS-1:0] region_re, region_we, region_hit;
   logic                   smr_open, smr_gen, smr_hit;

   smad_cfg_regs #(
      .NUM_REGIONS(NUM_REGIONS), .ATTR_OFS(ATTR_OFS), .SMR_OFS(SMR_OFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .region_re(region_re),
      .region_we(region_we), .smr_open(smr_open), .smr_gen(smr_gen)
   );

   smad_region_match #(
      .ADDR_W(ADDR_W), .NUM_EXP(NUM_EXP), .BIOS_BASE(BIOS_BASE), .BIOS_SIZE(BIOS_SIZE),
      .EXP_BASE(EXP_BASE), .EXP_SIZE(EXP_SIZE), .SMR_BASE(SMR_BASE), .SMR_SIZE(SMR_SIZE)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr),
      .region_hit(region_hit), .smr_hit(smr_hit)
   );

   smad_route #(
      .NUM_REGIONS(NUM_REGIONS)
   ) u_route (
      .clk(clk), .rst_n(rst_n), .region_hit(region_hit), .region_re(region_re),
      .region_we(region_we), .smr_hit(smr_hit), .smr_open(smr_open),
      .smr_gen(smr_gen), .acc_write(acc_write), .acc_smm(acc_smm),
      .tgt_dram(tgt_dram), .tgt_hit(tgt_hit)
   );

   AST_CFG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 8'(SMR_OFS)) ##1 (cfg_addr == 8'(SMR_OFS))
      |-> (cfg_rdata[7:3] == $past(cfg_wdata[7:3]))); // R10
endmodule

// File: tb/sim_smad_decoder.sv
`timescale 1ns/1ps
module sim_smad_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        acc_smm = 1'b0;
   logic        tgt_dram, tgt_hit;

   always #2.5 clk = ~clk;

   smad_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
      .acc_write(acc_write), .acc_smm(acc_smm), .tgt_dram(tgt_dram), .tgt_hit(tgt_hit)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 0;
   string phase = "R1";
   logic [7:0] m_attr [7];
   logic [7:0] m_smr;

   function automatic logic [7:0] ref_read(input logic [7:0] a);
      if (a >= 8'h59 && a <= 8'h5F) return m_attr[a - 8'h59];
      if (a == 8'h72) return m_smr;
      return 8'h00;
   endfunction

   function automatic void ref_write(input logic [7:0] a, input logic [7:0] d);
      if (a >= 8'h59 && a <= 8'h5F) m_attr[a - 8'h59] = d;
      else if (a == 8'h72) m_smr = {d[7:3], 3'b010};
   endfunction

   function automatic void ref_decode(input longint a, input bit w, input bit smm,
                                      output bit hit, output bit dram, output string tag);
      int idx;
      logic [7:0] by;
      logic [3:0] nib;
      hit = 0; dram = 0; tag = "R9";
      if (a >= 'hA0000 && a < 'hC0000) begin
         hit = 1;
         tag = smm ? "R8" : "R7";
         dram = (smm && m_smr[3]) ? 1'b1 : m_smr[6];
         return;
      end
      if (a >= 'hF0000 && a < 'h100000) idx = 0;
      else if (a >= 'hC0000 && a < 'hF0000) idx = int'((a - 'hC0000) / 'h4000) + 1;
      else return;
      hit = 1; tag = "R6";
      by = m_attr[(idx + 1) / 2];
      nib = (idx % 2 == 1) ? by[3:0] : by[7:4];
      dram = w ? nib[1] : nib[0];
   endfunction

   task automatic check();
      bit eh, ed;
      string tg;
      logic [7:0] er;
      er = ref_read(cfg_addr);
      ref_decode(longint'(acc_addr), acc_write, acc_smm, eh, ed, tg);
      n_cmp += 3;
      if (cfg_rdata !== er) begin
         n_bad++;
         $display("FAIL %s/R2 cfg_rdata @%h act=%h exp=%h", phase, cfg_addr, cfg_rdata, er);
      end
      if (tgt_hit !== eh) begin
         n_bad++;
         $display("FAIL %s/%s tgt_hit @%h act=%b exp=%b", phase, tg, acc_addr, tgt_hit, eh);
      end
      if (tgt_dram !== ed) begin
         n_bad++;
         $display("FAIL %s/%s tgt_dram @%h w=%b smm=%b act=%b exp=%b",
                  phase, tg, acc_addr, acc_write, acc_smm, tgt_dram, ed);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      check();
      if (cfg_wr && rst_n) ref_write(cfg_addr, cfg_wdata);
      @(posedge clk);
      #1;
   endtask

   task automatic cw(input logic [7:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic acc(input logic [31:0] a, input bit w, input bit s);
      acc_addr = a; acc_write = w; acc_smm = s;
      tick();
   endtask

   task automatic sweep_all();
      for (int r = 0; r < 13; r++) begin
         longint lo = (r == 0) ? 'hF0000 : 'hC0000 + longint'(r - 1) * 'h4000;
         longint sz = (r == 0) ? 'h10000 : 'h4000;
         for (int k = 0; k < 4; k++) begin
            acc(32'(lo), k[0], k[1]);
            acc(32'(lo + sz - 1), k[0], k[1]);
         end
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL %s watchdog expired", phase);
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
      m_smr = 8'h02;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset contents and routing
      phase = "R1";
      for (int a = 'h58; a <= 'h73; a++) begin cfg_addr = 8'(a); tick(); end
      sweep_all();
      acc(32'hA0000, 0, 0); acc(32'hBFFFF, 1, 1);

      // R2: unmapped offsets ignore writes and read zero
      phase = "R2";
      cw(8'h58, 8'hFF); cw(8'h60, 8'hFF); cw(8'h71, 8'hFF); cw(8'h73, 8'hFF); cw(8'h00, 8'hFF);
      foreach (m_attr[i]) begin cfg_addr = 8'(8'h59 + i); tick(); end
      cfg_addr = 8'h60; tick();
      cfg_addr = 8'h72; tick();
      sweep_all();
      for (int i = 0; i < 7; i++) begin
         cw(8'(8'h59 + i), 8'(8'h31 * (i + 1)));
         tick();
      end

      // R3: fixed low bits of the SMRAM byte
      phase = "R3";
      cw(8'h72, 8'h00); tick();
      cw(8'h72, 8'hFF); tick();
      cw(8'h72, 8'h05); tick();

      // R4 and R5: one nibble at a time selects one region
      phase = "R5";
      for (int b = 0; b < 7; b++) begin
         for (int h = 0; h < 2; h++) begin
            for (int i = 0; i < 7; i++) cw(8'(8'h59 + i), 8'h00);
            cw(8'(8'h59 + b), h ? 8'h30 : 8'h03);
            phase = "R4";
            sweep_all();
            phase = "R5";
         end
      end

      // R6: each flag combination in every region
      phase = "R6";
      for (int v = 0; v < 4; v++) begin
         for (int i = 0; i < 7; i++) cw(8'(8'h59 + i), 8'(v * 8'h11));
         sweep_all();
      end

      // R11: low nibble of the first attribute byte steers nothing
      phase = "R11";
      cw(8'h59, 8'h0F);
      cfg_addr = 8'h59; tick();
      sweep_all();

      // R7 and R8: SMRAM window under every flag combination
      for (int v = 0; v < 4; v++) begin
         cw(8'h72, 8'((v[0] ? 8'h40 : 8'h00) | (v[1] ? 8'h08 : 8'h00)));
         for (int k = 0; k < 4; k++) begin
            phase = k[1] ? "R8" : "R7";
            acc(32'hA0000, k[0], k[1]);
            acc(32'hB5555, k[0], k[1]);
            acc(32'hBFFFF, k[0], k[1]);
         end
      end

      // R9: addresses outside every window
      phase = "R9";
      cw(8'h72, 8'h48);
      for (int i = 0; i < 7; i++) cw(8'(8'h59 + i), 8'hFF);
      acc(32'h9FFFF, 0, 1); acc(32'h100000, 1, 1); acc(32'h0, 0, 0);
      acc(32'hFFFFFFFF, 1, 0); acc(32'h000F0000 | 32'h1000_0000, 0, 1);

      // R10: write and access back to back, mixed traffic
      phase = "R10";
      for (int n = 0; n < 3000; n++) begin
         int sel = $urandom_range(0, 9);
         acc_addr  = 32'($urandom_range(32'h90000, 32'h10FFFF));
         acc_write = 1'($urandom_range(0, 1));
         acc_smm   = 1'($urandom_range(0, 1));
         if (sel < 3) begin
            cfg_addr  = (sel == 0) ? 8'h72 : 8'($urandom_range(8'h57, 8'h61));
            cfg_wdata = 8'($urandom_range(0, 255));
            cfg_wr    = 1'b1;
         end else begin
            cfg_addr = 8'($urandom_range(8'h57, 8'h73));
         end
         tick();
         cfg_wr = 1'b0;
      end

      finish_run();
   end
endmodule